// File: doc/BRIEF.md
# Rate-Window Busy Generator

This block raises a busy level that throttles the trigger stream without any feedback from the front-end electronics. Event sizes are taken to be worst case, so two sliding time windows over the history of accepted triggers stand in for buffer occupancy. The short window guards the small front-end buffers, which hold only a few events. The long window guards the receiver buffers, each of which holds more than a hundred events. Time is measured in ticks of a timebase input. The window lengths in ticks and the trigger limits per window are parameters. The defaults are 7 triggers in 50 ticks and 100 triggers in 1000 ticks, which with a 1 ms tick gives 50 ms and 1 s.

Each receiver buffer also reports two flags, one above its high-water mark and one below its low-water mark. A per-receiver latch sets on the high flag and clears on the low flag. Busy is the OR of the two window limits and all watermark latches. A trigger that arrives while busy is high is rejected. It is not entered into the history, and it advances a wrapping reject counter.

Top module: `rate_busy_gen`

## Requirements
- R1: After reset, busy is 0, rejectCount is 0 and the trigger history is empty.
- R2: A trigger accepted in a cycle has age 0. Age grows by one on each cycle with tick high. Busy is 1 while at least SHORT_LIMIT accepted triggers have age below SHORT_TICKS.
- R3: Busy is 1 while at least LONG_LIMIT accepted triggers have age below LONG_TICKS, even when the short window is under its limit.
- R4: rxHigh[i]=1 sets the watermark latch of receiver i. The latch stays set until rxLow[i]=1 clears it. When both flags are 1 in the same cycle, the latch is set. The low flag of a different receiver does not affect it.
- R5: Busy is the OR of the short-window limit, the long-window limit and the watermark latches of all NUM_RX receivers. One receiver is enough to raise it.
- R6: A trigger in a cycle with busy=1 is not recorded in the history, and rejectCount increases by one, wrapping modulo 2^REJ_W.
- R7: Busy depends only on registered state. A change it causes appears in the cycle right after the clock edge that captures the trigger, tick or flag.
- R8: An entry leaves a window when its age reaches that window's length, and busy falls in that same cycle if no other source holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | 1 | Trigger pulse, one per cycle at most |
| tick | input | 1 | Timebase tick that ages the history |
| rxHigh | input | NUM_RX | Per-receiver flag, buffer above its high-water mark |
| rxLow | input | NUM_RX | Per-receiver flag, buffer below its low-water mark |
| busy | output | 1 | Busy level |
| rejectCount | output | REJ_W | Wrapping count of rejected triggers |

## Verification
The assertions check the following on every cycle:
- no trigger enters the history while busy is high;
- each rejection advances the counter by exactly one;
- a high flag raises busy one cycle later;
- a set latch survives every cycle without a low flag;
- a fresh entry starts at age zero;
- the window results move only on a push or a tick.

Only the bench's scenarios can show the counting itself. These are the exact cycle when the seventh quick trigger or the hundredth spaced trigger raises busy, and the exact tick on which aging releases it. They also show that rejected triggers never count toward either window. A behavioural reference model holds the acceptance times in a queue and follows all of these cycle by cycle.

// File: rtl/rate_busy_pkg.sv
package rate_busy_pkg;
  typedef struct packed {
    logic push;
    logic tick;
  } histCtl_t;
endpackage

// File: rtl/busy_hist.sv
module busy_hist
  import rate_busy_pkg::*;
#(
  parameter int SHORT_LIMIT = 7,
  parameter int LONG_LIMIT  = 100,
  parameter int SHORT_TICKS = 50,
  parameter int LONG_TICKS  = 1000
) (
  input  logic     clk,
  input  logic     rstN,
  input  histCtl_t ctl,
  output logic     shortHit,
  output logic     longHit
);
  localparam int DEPTH = LONG_LIMIT;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int AGE_W = $clog2(LONG_TICKS + 1);

  logic [AGE_W-1:0] ageMem [DEPTH];
  logic [DEPTH-1:0] validMem;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] shortIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPtr <= '0;
    else if (ctl.push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
  end

  // Each slot ages by itself and saturates at the long window length
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validMem[i] <= 1'b0;
        ageMem[i]   <= '0;
      end else if (ctl.push && wrPtr == PTR_W'(i)) begin
        validMem[i] <= 1'b1;
        ageMem[i]   <= '0;
      end else if (ctl.tick && validMem[i] && ageMem[i] < AGE_W'(LONG_TICKS)) begin
        ageMem[i] <= ageMem[i] + AGE_W'(1);
      end
    end
  end

  // The N-th most recent entry decides whether N entries sit in the window
  always_comb begin
    if (wrPtr >= PTR_W'(SHORT_LIMIT)) shortIdx = wrPtr - PTR_W'(SHORT_LIMIT);
    else shortIdx = wrPtr + PTR_W'(DEPTH - SHORT_LIMIT);
    shortHit = validMem[shortIdx] && (ageMem[shortIdx] < AGE_W'(SHORT_TICKS));
    longHit  = validMem[wrPtr] && (ageMem[wrPtr] < AGE_W'(LONG_TICKS));
  end

  p_fresh_age_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |=> (ageMem[$past(wrPtr)] == '0) && validMem[$past(wrPtr)]);

  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.push && !ctl.tick) |=> (shortHit == $past(shortHit)) && (longHit == $past(longHit)));
endmodule

// File: rtl/busy_ctl.sv
module busy_ctl
  import rate_busy_pkg::*;
#(
  parameter int NUM_RX = 4,
  parameter int REJ_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic              tick,
  input  logic [NUM_RX-1:0] rxHigh,
  input  logic [NUM_RX-1:0] rxLow,
  input  logic              shortHit,
  input  logic              longHit,
  output histCtl_t          ctl,
  output logic              busy,
  output logic [REJ_W-1:0]  rejectCount
);
  logic [NUM_RX-1:0] markLatch;
  logic              markAny;

  for (genvar i = 0; i < NUM_RX; i++) begin : g_mark
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) markLatch[i] <= 1'b0;
      else if (rxHigh[i]) markLatch[i] <= 1'b1;
      else if (rxLow[i]) markLatch[i] <= 1'b0;
    end
  end

  assign markAny  = |markLatch;
  assign busy     = shortHit | longHit | markAny;
  assign ctl.push = trigIn & ~busy;
  assign ctl.tick = tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rejectCount <= '0;
    else if (trigIn && busy) rejectCount <= rejectCount + REJ_W'(1);
  end

  p_reject_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn && busy) |=> rejectCount == $past(rejectCount) + REJ_W'(1));

  p_no_push_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.push);

  p_mark_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (markAny && !(|rxLow)) |=> markAny);

  p_high_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|rxHigh) |=> busy);
endmodule

// File: rtl/rate_busy_gen.sv
module rate_busy_gen
  import rate_busy_pkg::*;
#(
  parameter int NUM_RX      = 4,
  parameter int SHORT_LIMIT = 7,
  parameter int LONG_LIMIT  = 100,
  parameter int SHORT_TICKS = 50,
  parameter int LONG_TICKS  = 1000,
  parameter int REJ_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic              tick,
  input  logic [NUM_RX-1:0] rxHigh,
  input  logic [NUM_RX-1:0] rxLow,
  output logic              busy,
  output logic [REJ_W-1:0]  rejectCount
);
  histCtl_t ctl;
  logic     shortHit;
  logic     longHit;

  busy_ctl #(.NUM_RX(NUM_RX), .REJ_W(REJ_W)) i_ctl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .tick(tick),
    .rxHigh(rxHigh), .rxLow(rxLow), .shortHit(shortHit), .longHit(longHit),
    .ctl(ctl), .busy(busy), .rejectCount(rejectCount)
  );

  busy_hist #(
    .SHORT_LIMIT(SHORT_LIMIT), .LONG_LIMIT(LONG_LIMIT),
    .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)
  ) i_hist (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shortHit(shortHit), .longHit(longHit)
  );
endmodule

// File: tb/test_rate_busy_gen.sv
module test_rate_busy_gen;
  localparam int NRX = 4;
  localparam int SL = 7, LL = 100, ST = 50, LT = 1000, RW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0;
  logic tick = 1'b0;
  logic [NRX-1:0] rxHigh = '0;
  logic [NRX-1:0] rxLow = '0;
  logic busy;
  logic [RW-1:0] rejectCount;

  always #4 clk = ~clk;

  rate_busy_gen #(.NUM_RX(NRX), .SHORT_LIMIT(SL), .LONG_LIMIT(LL),
    .SHORT_TICKS(ST), .LONG_TICKS(LT), .REJ_W(RW)) i_rate_busy_gen (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .tick(tick),
    .rxHigh(rxHigh), .rxLow(rxLow), .busy(busy), .rejectCount(rejectCount));

  int checks = 0;
  int errors = 0;
  string phaseTag = "R1";

  // Behavioural reference
  int stamps[$];
  int tc = 0;
  int rejM = 0;
  bit [NRX-1:0] latchM = '0;

  function automatic bit busyModel();
    int ns = 0;
    int nl = 0;
    foreach (stamps[k]) begin
      if (tc - stamps[k] < ST) ns++;
      if (tc - stamps[k] < LT) nl++;
    end
    return (ns >= SL) || (nl >= LL) || (latchM != '0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      stamps.delete(); tc = 0; rejM = 0; latchM = '0;
    end else begin
      bit b;
      b = busyModel();
      if (tick) tc++;
      for (int i = 0; i < NRX; i++) begin
        if (rxHigh[i]) latchM[i] = 1'b1;
        else if (rxLow[i]) latchM[i] = 1'b0;
      end
      if (trigIn) begin
        if (b) rejM = (rejM + 1) % (1 << RW);
        else stamps.push_back(tc);
      end
      while (stamps.size() > 0 && tc - stamps[0] >= LT) void'(stamps.pop_front());
    end
    #2;
    if (rstN) begin
      checks++;
      if (busy !== busyModel() || rejectCount !== RW'(rejM)) begin
        errors++;
        $display("FAIL %s model busy act=%0b exp=%0b reject act=%0d exp=%0d",
                 phaseTag, busy, busyModel(), rejectCount, rejM);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=0", wd);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 reject", 32'(rejectCount), 0);
    rstN = 1'b1;
    cyc(2);
    chk("R1 idle busy", 32'(busy), 0);

    // Watermark hysteresis
    phaseTag = "R4";
    rxHigh[2] = 1'b1; cyc(1); rxHigh[2] = 1'b0;
    chk("R5 one receiver raises busy", 32'(busy), 1);
    cyc(5);
    chk("R4 latch holds", 32'(busy), 1);
    rxLow[1] = 1'b1; cyc(1); rxLow[1] = 1'b0;
    chk("R4 other low ignored", 32'(busy), 1);

    // Reject while busy
    phaseTag = "R6";
    trigIn = 1'b1; cyc(1); trigIn = 1'b0;
    chk("R6 reject count", 32'(rejectCount), 1);
    trigIn = 1'b1; cyc(1); trigIn = 1'b0;
    chk("R6 reject count 2", 32'(rejectCount), 2);
    rxLow[2] = 1'b1; cyc(1); rxLow[2] = 1'b0;
    chk("R4 low releases", 32'(busy), 0);
    rxHigh[0] = 1'b1; rxLow[0] = 1'b1; cyc(1); rxHigh[0] = 1'b0; rxLow[0] = 1'b0;
    chk("R4 high wins", 32'(busy), 1);
    rxLow[0] = 1'b1; cyc(1); rxLow[0] = 1'b0;
    chk("R4 release again", 32'(busy), 0);

    // Short window, no ticks: rejected triggers must not count
    phaseTag = "R2";
    for (int i = 0; i < SL - 1; i++) begin
      trigIn = 1'b1; cyc(1);
    end
    trigIn = 1'b0;
    chk("R6 rejected not recorded", 32'(busy), 0);
    trigIn = 1'b1; cyc(1); trigIn = 1'b0;
    chk("R7 R2 seventh trigger busy next cycle", 32'(busy), 1);
    chk("R2 reject unchanged", 32'(rejectCount), 2);

    // Aging out of the short window
    phaseTag = "R8";
    tick = 1'b1;
    cyc(ST - 1);
    chk("R8 still inside at age 49", 32'(busy), 1);
    cyc(1);
    chk("R8 leaves at age 50", 32'(busy), 0);
    cyc(LT + 10);

    // Long window with spaced triggers
    phaseTag = "R3";
    for (int n = 1; n <= LL; n++) begin
      trigIn = 1'b1; cyc(1); trigIn = 1'b0;
      if (n == LL - 1) chk("R3 below long limit", 32'(busy), 0);
      if (n == LL) chk("R3 long limit busy", 32'(busy), 1);
      if (n < LL) cyc(8);
    end
    cyc(3);
    trigIn = 1'b1; cyc(1); trigIn = 1'b0;
    chk("R3 R6 reject under long busy", 32'(rejectCount), 3);
    cyc(LT);
    chk("R8 long window drains", 32'(busy), 0);
    tick = 1'b0;
    cyc(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule